// File: doc/BRIEF.md
# Aligned Access Chunk Splitter

The block turns a byte-range request into a run of bus accesses. A request is a start offset and a total byte count. The block breaks it into accesses of 1, 2 or 4 bytes, and each access sits on an address that is a multiple of its own size. Each access is chosen as large as both the current offset's alignment and the bytes still owed allow. So an unaligned head is walked up to a word boundary with smaller accesses, the middle goes out in words, and a short tail is covered by halfwords and bytes.

Requests arrive on a valid/ready port and are taken only while the block is idle. Chunks leave one at a time on a second valid/ready port, each with its address and a size code. The downstream side can flag an error together with the handshake of any chunk; that abandons the rest of the request. A one-cycle done pulse closes every request and carries an error flag.

Top module: `chunk_splitter`

## Requirements
- R1: The alignment limit of a chunk is the lowest set bit of the current offset, with the 4-byte bit forced on: an odd offset gives 1 byte, an offset equal to 2 mod 4 gives 2 bytes, and an offset that is a multiple of 4 gives 4 bytes.
- R2: The count limit of a chunk is the highest power of two that does not exceed the remaining byte count, capped at 4: a remainder of 1 gives 1 byte, 2 or 3 gives 2 bytes, and 4 or more gives 4 bytes.
- R3: The chunk size is the smaller of the two limits, output on `chunkSize` as code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes; code 3 never appears while `chunkValid` is high, and `chunkAddr` is always a multiple of the chunk size.
- R4: After each accepted chunk the address advances and the remaining count shrinks by the chunk size. Chunks continue until the count reaches zero. The first chunk's address equals the request offset, and the done pulse follows the cycle in which the last chunk is accepted.
- R5: A request with a zero count issues no chunk and raises `doneValid` with `doneErr` low in the cycle after acceptance.
- R6: `reqReady` is high only while idle; a request is accepted in the cycle after reset and in the cycle after a done pulse, and `reqValid` and request data have no effect while chunks are outstanding.
- R7: When `chunkErr` is high during a chunk handshake, no further chunk is issued and `doneValid` rises in the next cycle with `doneErr` high.
- R8: While `chunkValid` is high and `chunkReady` is low, `chunkValid`, `chunkAddr` and `chunkSize` hold their values.
- R9: `doneValid` is high for exactly one cycle per request, and `reqReady` is high in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request taken when reqValid is high |
| reqOffset | input | ADDR_W | Start byte offset |
| reqCount | input | CNT_W | Total byte count |
| chunkValid | output | 1 | A chunk is presented |
| chunkReady | input | 1 | Downstream takes the chunk |
| chunkErr | input | 1 | Downstream error, qualified by the chunk handshake |
| chunkAddr | output | ADDR_W | Chunk byte address |
| chunkSize | output | 2 | Chunk size code (0:1, 1:2, 2:4 bytes) |
| doneValid | output | 1 | One-cycle end-of-request pulse |
| doneErr | output | 1 | Request ended on a downstream error |

## Verification
The bench builds the block with its default 32-bit offset and count widths. At these widths an offset just below the top of the address space is reachable, so the last chunks of a request end at the wrap point. A count of zero is also reachable through the same full-width compare. Directed requests cover every start phase modulo 4 and tails of 1, 2 and 3 bytes. They also cover a stalled downstream, an error injected on the first and on a later chunk, and a request held on the input while a run is in flight.

// File: rtl/chunk_pkg.sv
package chunk_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } sizeCode_e;

  typedef struct packed {
    logic load;
    logic advance;
  } ctrlStrobes_t;

endpackage

// File: rtl/chunk_datapath.sv
module chunk_datapath
  import chunk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [CNT_W-1:0]  reqCount,
  output logic [ADDR_W-1:0] chunkAddr,
  output logic [1:0]        chunkSize,
  output logic              reqZero,
  output logic              lastChunk
);

  logic [ADDR_W-1:0] offsetQ;
  logic [CNT_W-1:0]  remQ;
  logic [1:0]        alignCode;
  logic [1:0]        countCode;
  logic [1:0]        sizeCode;
  logic [2:0]        chunkBytes;

  // alignment limit: lowest set bit of offset, 4-byte bit forced on
  always_comb begin
    if (offsetQ[0])      alignCode = SZ_BYTE;
    else if (offsetQ[1]) alignCode = SZ_HALF;
    else                 alignCode = SZ_WORD;
  end

  // count limit: top set bit of remaining count, capped at 4 bytes
  always_comb begin
    if (|remQ[CNT_W-1:2]) countCode = SZ_WORD;
    else if (remQ[1])     countCode = SZ_HALF;
    else                  countCode = SZ_BYTE;
  end

  assign sizeCode   = (alignCode < countCode) ? alignCode : countCode;
  assign chunkBytes = 3'd1 << sizeCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ <= '0;
      remQ    <= '0;
    end else if (strobes.load) begin
      offsetQ <= reqOffset;
      remQ    <= reqCount;
    end else if (strobes.advance) begin
      offsetQ <= offsetQ + ADDR_W'(chunkBytes);
      remQ    <= remQ - CNT_W'(chunkBytes);
    end
  end

  assign chunkAddr = offsetQ;
  assign chunkSize = sizeCode;
  assign reqZero   = (reqCount == '0);
  assign lastChunk = (remQ == CNT_W'(chunkBytes));

endmodule

// File: rtl/chunk_control.sv
module chunk_control
  import chunk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqZero,
  input  logic         chunkReady,
  input  logic         chunkErr,
  input  logic         lastChunk,
  output logic         reqReady,
  output logic         chunkValid,
  output logic         doneValid,
  output logic         doneErr,
  output ctrlStrobes_t strobes
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } state_e;

  state_e stateQ, stateD;
  logic   errQ, errD;
  logic   takeReq, takeChunk;

  assign takeReq   = (stateQ == ST_IDLE) && reqValid;
  assign takeChunk = (stateQ == ST_ISSUE) && chunkReady;

  always_comb begin
    stateD = stateQ;
    errD   = errQ;
    unique case (stateQ)
      ST_IDLE: begin
        errD = 1'b0;
        if (reqValid) stateD = reqZero ? ST_DONE : ST_ISSUE;
      end
      ST_ISSUE: begin
        if (chunkReady) begin
          if (chunkErr) begin
            errD   = 1'b1;
            stateD = ST_DONE;
          end else if (lastChunk) begin
            stateD = ST_DONE;
          end
        end
      end
      ST_DONE:  stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      errQ   <= errD;
    end
  end

  assign strobes.load    = takeReq;
  assign strobes.advance = takeChunk && !chunkErr;
  assign reqReady        = (stateQ == ST_IDLE);
  assign chunkValid      = (stateQ == ST_ISSUE);
  assign doneValid       = (stateQ == ST_DONE);
  assign doneErr         = (stateQ == ST_DONE) && errQ;

endmodule

// File: rtl/chunk_splitter.sv
module chunk_splitter
  import chunk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [CNT_W-1:0]  reqCount,
  output logic              chunkValid,
  input  logic              chunkReady,
  input  logic              chunkErr,
  output logic [ADDR_W-1:0] chunkAddr,
  output logic [1:0]        chunkSize,
  output logic              doneValid,
  output logic              doneErr
);

  ctrlStrobes_t strobes;
  logic         reqZero;
  logic         lastChunk;

  chunk_control ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqZero    (reqZero),
    .chunkReady (chunkReady),
    .chunkErr   (chunkErr),
    .lastChunk  (lastChunk),
    .reqReady   (reqReady),
    .chunkValid (chunkValid),
    .doneValid  (doneValid),
    .doneErr    (doneErr),
    .strobes    (strobes)
  );

  chunk_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqOffset (reqOffset),
    .reqCount  (reqCount),
    .chunkAddr (chunkAddr),
    .chunkSize (chunkSize),
    .reqZero   (reqZero),
    .lastChunk (lastChunk)
  );

endmodule

// File: rtl/chunk_splitter_chk.sv
module chunk_splitter_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              chunkValid,
  input logic              chunkReady,
  input logic              chunkErr,
  input logic [ADDR_W-1:0] chunkAddr,
  input logic [1:0]        chunkSize,
  input logic              doneValid,
  input logic              doneErr
);

  a_r3_legal_size: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid |-> (chunkSize != 2'd3));

  a_r3_aligned_addr: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid |-> ((chunkAddr & ((ADDR_W'(1) << chunkSize) - ADDR_W'(1))) == '0));

  a_r4_addr_advance: assert property (@(posedge clk) disable iff (!rstN)
    (chunkValid && chunkReady && !chunkErr) |=>
      (!chunkValid || chunkAddr == $past(chunkAddr) + (ADDR_W'(1) << $past(chunkSize))));

  a_r6_ready_idle_only: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && (chunkValid || doneValid)));

  a_r6_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  a_r7_err_stops_chunks: assert property (@(posedge clk) disable iff (!rstN)
    (chunkValid && chunkReady && chunkErr) |=> (doneValid && doneErr && !chunkValid));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (chunkValid && !chunkReady) |=>
      (chunkValid && $stable(chunkAddr) && $stable(chunkSize)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady));

endmodule

bind chunk_splitter chunk_splitter_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .chunkValid (chunkValid),
  .chunkReady (chunkReady),
  .chunkErr   (chunkErr),
  .chunkAddr  (chunkAddr),
  .chunkSize  (chunkSize),
  .doneValid  (doneValid),
  .doneErr    (doneErr)
);

// File: tb/chunk_splitter_tb_top.sv
module chunk_splitter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqOffset = '0;
  logic [31:0] reqCount = '0;
  logic        chunkValid;
  logic        chunkReady = 1'b0;
  logic        chunkErr = 1'b0;
  logic [31:0] chunkAddr;
  logic [1:0]  chunkSize;
  logic        doneValid;
  logic        doneErr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  chunk_splitter dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqOffset(reqOffset), .reqCount(reqCount),
    .chunkValid(chunkValid), .chunkReady(chunkReady), .chunkErr(chunkErr),
    .chunkAddr(chunkAddr), .chunkSize(chunkSize),
    .doneValid(doneValid), .doneErr(doneErr)
  );

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // largest of 4,2,1 bytes that divides the offset and fits the remainder
  function automatic int unsigned modelBytes(input logic [31:0] off, input logic [31:0] rem);
    int unsigned b = 4;
    while (b > 1 && (rem < b || (off % b) != 0)) b = b / 2;
    return b;
  endfunction

  function automatic logic [1:0] codeOf(input int unsigned b);
    return (b == 4) ? 2'd2 : (b == 2) ? 2'd1 : 2'd0;
  endfunction

  // one request; errIdx < 0 means no error; stall holds off every other chunk cycle
  task automatic runCase(input string tag, input logic [31:0] off, input logic [31:0] cnt,
                         input int errIdx, input bit stall);
    logic [31:0] mOff = off;
    logic [31:0] mRem = cnt;
    int          idx = 0;
    int          cyc = 0;
    bit          errSent = 1'b0;
    bit          finished = 1'b0;
    check({tag, " R6 idle ready"}, reqReady == 1'b1, reqReady, 1);
    reqOffset = off;
    reqCount  = cnt;
    reqValid  = 1'b1;
    @(negedge clk);
    // keep a different request on the input: must be ignored (R6)
    reqOffset = ~off;
    reqCount  = 32'd1;
    for (int n = 0; n < 200 && !finished; n++) begin
      chunkReady = 1'b0;
      chunkErr   = 1'b0;
      if (doneValid) begin
        check({tag, " R5/R4 no bytes owed at done"}, errSent || mRem == 0, mRem, 0);
        check({tag, " R7 done error flag"}, doneErr == errSent, doneErr, errSent);
        check({tag, " R7 chunk count"}, errSent ? (idx == errIdx + 1) : 1'b1, idx, errIdx + 1);
        reqValid = 1'b0;
        finished = 1'b1;
      end else if (chunkValid) begin
        int unsigned b = modelBytes(mOff, mRem);
        check({tag, " R6 ready low while busy"}, reqReady == 1'b0, reqReady, 0);
        check({tag, " R4 chunk addr"}, chunkAddr == mOff, chunkAddr, mOff);
        check({tag, " R1/R2/R3 chunk size"}, chunkSize == codeOf(b), chunkSize, codeOf(b));
        check({tag, " R7 no chunk after error"}, !errSent, 1, 0);
        if (!(stall && (cyc % 2 == 0))) begin
          chunkReady = 1'b1;
          if (idx == errIdx) begin
            chunkErr = 1'b1;
            errSent  = 1'b1;
          end else begin
            mOff = mOff + b;
            mRem = mRem - b;
          end
          idx++;
        end
        cyc++;
      end else begin
        check({tag, " R4 chunk or done expected"}, 1'b0, 0, 1);
      end
      @(negedge clk);
    end
    chunkReady = 1'b0;
    chunkErr   = 1'b0;
    check({tag, " R9 request finished"}, finished, finished, 1);
    check({tag, " R9 done is a pulse"}, doneValid == 1'b0, doneValid, 0);
    check({tag, " R9 ready after done"}, reqReady == 1'b1, reqReady, 1);
  endtask

  task automatic testReset();
    check("R6 reset ready", reqReady == 1'b1, reqReady, 1);
    check("R4 reset no chunk", chunkValid == 1'b0, chunkValid, 0);
    check("R9 reset no done", doneValid == 1'b0, doneValid, 0);
  endtask

  task automatic testZero();
    runCase("zero count R5", 32'h0000_0013, 32'd0, -1, 1'b0);
  endtask

  task automatic testAligned();
    runCase("aligned words R1", 32'h0000_1000, 32'd12, -1, 1'b0);
  endtask

  task automatic testOddHead();
    runCase("odd head R1", 32'h0000_0001, 32'd7, -1, 1'b0);
    runCase("phase3 R1", 32'h0000_0003, 32'd3, -1, 1'b0);
    runCase("phase2 R2", 32'h0000_0006, 32'd5, -1, 1'b0);
  endtask

  task automatic testTails();
    runCase("tail 1 R2", 32'h0000_0002, 32'd1, -1, 1'b0);
    runCase("tail 3 R2", 32'h0000_0040, 32'd7, -1, 1'b0);
    runCase("long mixed R3", 32'h0000_0105, 32'd23, -1, 1'b0);
  endtask

  task automatic testWrap();
    runCase("top of space R4", 32'hFFFF_FFFD, 32'd3, -1, 1'b0);
  endtask

  task automatic testStall();
    runCase("stall R8", 32'h0000_0201, 32'd10, -1, 1'b1);
  endtask

  task automatic testError();
    runCase("error first R7", 32'h0000_0000, 32'd8, 0, 1'b0);
    runCase("error later R7", 32'h0000_0001, 32'd9, 2, 1'b1);
    runCase("after error R7", 32'h0000_0002, 32'd6, -1, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZero();
    testAligned();
    testOddHead();
    testTails();
    testWrap();
    testStall();
    testError();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule